// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block services a circular list of 16-byte transfer descriptors kept in system memory on behalf of a serial bus transaction engine. Software sets the ring base address and the index of the last ring entry. It then writes a producer index and a run bit. The controller keeps its own consumer index. For every entry between the consumer and the producer index, it reads the descriptor over a 32-bit memory port and presents the decoded fields to the engine. It then holds until the engine reports a result.

Each result is written back in place into the second word of the descriptor: a status byte, a retry byte, a received count and a transmitted count. After that, the consumer index advances, wrapping at the programmed last index. A per-descriptor control bit asks for a completion interrupt. An error interrupt is raised for failed transfers when software has enabled it. A second per-descriptor bit halts the ring after a failure. The interrupt flags are cleared by writing ones to them.

Top module: `drd_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and neither `mem_req` nor `xfer_valid` is asserted.
- R2: While the run bit is set and the consumer index differs from the producer index, the block reads the four words of the descriptor at base + 16*tail + 4*k, for k = 0 to 3 in order. It presents the fields from little-endian byte lanes: byte 0 target/RW, byte 1 write length or command, byte 2 read length, byte 3 control, and words 2 and 3 the low and high halves of the 64-bit data pointer.
- R3: After the engine reports completion, exactly one write goes to word 1 (base + 16*tail + 4) with data {txcnt, rxcnt, retry, status} from bit 31 down. Words 0, 2 and 3 of the descriptor are never written.
- R4: The consumer index increments after each writeback and returns to 0 after it equals the last-index field (ring size register bits 7:0).
- R5: The status register carries the consumer index in bits 23:16. Bit 0 reads 1 from the start of a fetch until its writeback completes, and 0 otherwise.
- R6: Clearing the run bit while a descriptor is in flight lets that descriptor finish through writeback. No further descriptor is then started, and bit 0 of the status register falls.
- R7: Status bit 5 (done flag) is set when a descriptor whose control bit 6 is 1 completes, and is never set by a descriptor with control bit 6 clear.
- R8: Status bit 4 (error flag) is set when a completed descriptor returns a status byte with bit 0 (success) clear, but only when control register bit 4 (error interrupt enable) is 1.
- R9: Writing 1 to status bit 5 or bit 4 clears that flag, and `irq` is high exactly while either flag is set.
- R10: A failed descriptor whose control bit 7 is set clears the run bit, so later pending descriptors are not fetched.
- R11: Register map (byte offsets): 0x00 control (bit 0 run, bit 4 error enable, bits 23:16 producer index), 0x04 status, 0x08 ring size, 0x10 base address bits 31:0, 0x14 base address bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted (read data valid) |
| mem_rdata | input | 32 | Memory read data |
| xfer_valid | output | 1 | Descriptor presented to the engine |
| xfer_tgt | output | 8 | Target address with R/W bit |
| xfer_wlen | output | 8 | Write length or command byte |
| xfer_rlen | output | 8 | Read length |
| xfer_ctrl | output | 8 | Descriptor control byte |
| xfer_dptr | output | 64 | Data buffer pointer |
| xfer_done | input | 1 | Engine result valid |
| xfer_status | input | 8 | Result status byte (bit 0 success) |
| xfer_retry | input | 8 | Result retry byte |
| xfer_rxcnt | input | 8 | Bytes received |
| xfer_txcnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs the ring across its wrap point, where a design that mishandles the last-index compare would fetch from past the ring end or stall at index 3. It checks that the writeback lands only in word 1. A wrong byte offset would corrupt the target byte or the data pointer, and that shows up when the untouched words are read back. It issues a failed descriptor with the error enable off and then with stop-on-error set. A controller that ignored either bit would set a flag it should not, or go on to execute the next entry, whose preset word 1 would then be overwritten. It also drops the run bit in the middle of a long engine transfer. A design that aborted at once would skip the writeback, and one that ignored the stop would consume the remaining entries.

// File: rtl/drd_pkg.sv
package drd_pkg;
  localparam int WORD_W       = 32;
  localparam int DESC_BYTES   = 16;
  localparam int DESC_WORDS   = DESC_BYTES / (WORD_W / 8);
  localparam int RESULT_WORD  = 1;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_STAT    = 8'h04;
  localparam logic [7:0] OFF_RSIZE   = 8'h08;
  localparam logic [7:0] OFF_BASE_LO = 8'h10;
  localparam logic [7:0] OFF_BASE_HI = 8'h14;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_EIE_BIT  = 4;
  localparam int IDX_LSB      = 16;
  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_ERR_BIT   = 4;
  localparam int ST_DONE_BIT  = 5;
  localparam int DC_IRQ_BIT   = 6;
  localparam int DC_HALT_BIT  = 7;
  localparam int RS_OK_BIT    = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WBACK = 2'd3
  } seq_state_e;
endpackage

// File: rtl/drd_regs.sv
module drd_regs
  import drd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [IDX_W-1:0]  ring_last,
  output logic [IDX_W-1:0]  head_idx,
  output logic              run,
  output logic              err_ie,
  output logic              done_flag,
  output logic              err_flag,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              busy,
  input  logic              done_evt,
  input  logic              fail_evt,
  input  logic              stop_req
);
  localparam int HI_W = ADDR_W - 32;

  logic              run_q, run_d;
  logic              eie_q, eie_d;
  logic [IDX_W-1:0]  head_q, head_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic [31:0]       blo_q, blo_d;
  logic [HI_W-1:0]   bhi_q, bhi_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic wr_ctrl, wr_stat, wr_size, wr_blo, wr_bhi;

  assign wr_ctrl = reg_we && (reg_addr == OFF_CTRL[REG_AW-1:0]);
  assign wr_stat = reg_we && (reg_addr == OFF_STAT[REG_AW-1:0]);
  assign wr_size = reg_we && (reg_addr == OFF_RSIZE[REG_AW-1:0]);
  assign wr_blo  = reg_we && (reg_addr == OFF_BASE_LO[REG_AW-1:0]);
  assign wr_bhi  = reg_we && (reg_addr == OFF_BASE_HI[REG_AW-1:0]);

  always_comb begin
    run_d  = run_q;
    eie_d  = eie_q;
    head_d = head_q;
    last_d = last_q;
    blo_d  = blo_q;
    bhi_d  = bhi_q;
    done_d = done_q;
    err_d  = err_q;
    if (wr_ctrl) begin
      run_d  = reg_wdata[CTL_RUN_BIT];
      eie_d  = reg_wdata[CTL_EIE_BIT];
      head_d = reg_wdata[IDX_LSB +: IDX_W];
    end
    if (stop_req) run_d = 1'b0;
    if (wr_size) last_d = reg_wdata[IDX_W-1:0];
    if (wr_blo)  blo_d  = reg_wdata;
    if (wr_bhi)  bhi_d  = reg_wdata[HI_W-1:0];
    if (wr_stat) begin
      if (reg_wdata[ST_DONE_BIT]) done_d = 1'b0;
      if (reg_wdata[ST_ERR_BIT])  err_d  = 1'b0;
    end
    if (done_evt)           done_d = 1'b1;
    if (fail_evt && eie_q)  err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      eie_q  <= 1'b0;
      head_q <= '0;
      last_q <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      eie_q  <= eie_d;
      head_q <= head_d;
      last_q <= last_d;
      blo_q  <= blo_d;
      bhi_q  <= bhi_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL[REG_AW-1:0]: begin
        reg_rdata[CTL_RUN_BIT]          = run_q;
        reg_rdata[CTL_EIE_BIT]          = eie_q;
        reg_rdata[IDX_LSB +: IDX_W]     = head_q;
      end
      OFF_STAT[REG_AW-1:0]: begin
        reg_rdata[ST_BUSY_BIT]          = busy;
        reg_rdata[ST_ERR_BIT]           = err_q;
        reg_rdata[ST_DONE_BIT]          = done_q;
        reg_rdata[IDX_LSB +: IDX_W]     = tail_idx;
      end
      OFF_RSIZE[REG_AW-1:0]:   reg_rdata[IDX_W-1:0] = last_q;
      OFF_BASE_LO[REG_AW-1:0]: reg_rdata = blo_q;
      OFF_BASE_HI[REG_AW-1:0]: reg_rdata[HI_W-1:0] = bhi_q;
      default:                 reg_rdata = '0;
    endcase
  end

  assign ring_base = {bhi_q, blo_q};
  assign ring_last = last_q;
  assign head_idx  = head_q;
  assign run       = run_q;
  assign err_ie    = eie_q;
  assign done_flag = done_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/drd_seq.sv
module drd_seq
  import drd_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W-1:0]  ring_last,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tgt,
  output logic [7:0]        xfer_wlen,
  output logic [7:0]        xfer_rlen,
  output logic [7:0]        xfer_ctrl,
  output logic [63:0]       xfer_dptr,
  input  logic              xfer_done,
  input  logic [WORD_W-1:0] xfer_result,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              busy,
  output logic              done_evt,
  output logic              fail_evt,
  output logic              stop_req
);
  localparam int WIDX_W   = $clog2(DESC_WORDS);
  localparam int SHIFT    = $clog2(DESC_BYTES);
  localparam int BYTE_SH  = $clog2(WORD_W / 8);

  seq_state_e        state_q, state_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [IDX_W-1:0]  tail_q, tail_d;
  logic [WORD_W-1:0] res_q;
  logic              cap_en, res_en;
  logic [ADDR_W-1:0] desc_base, word_off;
  logic              failed;

  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_cap
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    w_q <= '0;
      else if (cap_en && widx_q == WIDX_W'(gi))      w_q <= mem_rdata;
    end
  end

  assign xfer_tgt  = g_cap[0].w_q[7:0];
  assign xfer_wlen = g_cap[0].w_q[15:8];
  assign xfer_rlen = g_cap[0].w_q[23:16];
  assign xfer_ctrl = g_cap[0].w_q[31:24];
  assign xfer_dptr = {g_cap[3].w_q, g_cap[2].w_q};
  assign failed    = !res_q[RS_OK_BIT];

  always_comb begin
    state_d    = state_q;
    widx_d     = widx_q;
    tail_d     = tail_q;
    cap_en     = 1'b0;
    res_en     = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    xfer_valid = 1'b0;
    done_evt   = 1'b0;
    fail_evt   = 1'b0;
    stop_req   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run && (tail_q != head_idx)) begin
          state_d = ST_FETCH;
          widx_d  = '0;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cap_en = 1'b1;
          if (widx_q == WIDX_W'(DESC_WORDS - 1)) state_d = ST_EXEC;
          else                                   widx_d  = widx_q + 1'b1;
        end
      end
      ST_EXEC: begin
        xfer_valid = 1'b1;
        if (xfer_done) begin
          res_en  = 1'b1;
          state_d = ST_WBACK;
        end
      end
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          tail_d   = (tail_q == ring_last) ? '0 : tail_q + 1'b1;
          done_evt = xfer_ctrl[DC_IRQ_BIT];
          fail_evt = failed;
          stop_req = failed && xfer_ctrl[DC_HALT_BIT];
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      tail_q  <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= xfer_result;
  end

  assign desc_base = ring_base + (ADDR_W'(tail_q) << SHIFT);
  assign word_off  = (state_q == ST_WBACK) ? (ADDR_W'(RESULT_WORD) << BYTE_SH)
                                           : (ADDR_W'(widx_q) << BYTE_SH);
  assign mem_addr  = desc_base + word_off;
  assign mem_wdata = res_q;
  assign tail_idx  = tail_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/drd_ring_ctrl.sv
module drd_ring_ctrl
  import drd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tgt,
  output logic [7:0]        xfer_wlen,
  output logic [7:0]        xfer_rlen,
  output logic [7:0]        xfer_ctrl,
  output logic [63:0]       xfer_dptr,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_status,
  input  logic [7:0]        xfer_retry,
  input  logic [7:0]        xfer_rxcnt,
  input  logic [7:0]        xfer_txcnt,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] ring_base;
  logic [IDX_W-1:0]  ring_last, head_idx, tail_idx;
  logic              run, err_ie, done_flag, err_flag, busy;
  logic              done_evt, fail_evt, stop_req;
  logic [31:0]       xfer_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n  = rst_sync_q[1];
  assign xfer_result = {xfer_txcnt, xfer_rxcnt, xfer_retry, xfer_status};

  drd_regs #(.REG_AW(REG_AW), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ring_base(ring_base), .ring_last(ring_last), .head_idx(head_idx),
    .run(run), .err_ie(err_ie), .done_flag(done_flag), .err_flag(err_flag),
    .tail_idx(tail_idx), .busy(busy),
    .done_evt(done_evt), .fail_evt(fail_evt), .stop_req(stop_req)
  );

  drd_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .run(run), .head_idx(head_idx), .ring_last(ring_last), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_tgt(xfer_tgt), .xfer_wlen(xfer_wlen),
    .xfer_rlen(xfer_rlen), .xfer_ctrl(xfer_ctrl), .xfer_dptr(xfer_dptr),
    .xfer_done(xfer_done), .xfer_result(xfer_result),
    .tail_idx(tail_idx), .busy(busy),
    .done_evt(done_evt), .fail_evt(fail_evt), .stop_req(stop_req)
  );

  assign irq = done_flag | err_flag;
endmodule

// File: rtl/drd_ring_ctrl_chk.sv
module drd_ring_ctrl_chk #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              xfer_valid,
  input logic              busy,
  input logic              run,
  input logic              err_ie,
  input logic              done_flag,
  input logic              err_flag,
  input logic [IDX_W-1:0]  tail_idx,
  input logic [IDX_W-1:0]  head_idx,
  input logic [IDX_W-1:0]  ring_last
);
  // R2: memory and engine phases never overlap
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !mem_req);

  // R3: every write targets word 1 of a descriptor
  a_r3_wb_word1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[3:0] == 4'h4));

  // R4: consumer index moves only on an accepted writeback
  a_r4_tail_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_idx != $past(tail_idx)) |-> $past(mem_req && mem_we && mem_ack));

  // R4: leaving the last index goes to zero
  a_r4_tail_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(tail_idx) == $past(ring_last)) && (tail_idx != $past(tail_idx))) |-> (tail_idx == '0));

  // R5: in-progress bit covers every memory and engine phase
  a_r5_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || xfer_valid) |-> busy);

  // R6: a new descriptor starts only when running with work pending
  a_r6_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run && (tail_idx != head_idx)));

  // R2: a memory request holds until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: done flag rises only at a writeback acceptance
  a_r7_done_at_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(mem_req && mem_we && mem_ack));

  // R8: error flag needs the enable
  a_r8_err_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(err_ie));
endmodule

bind drd_ring_ctrl drd_ring_ctrl_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .xfer_valid(xfer_valid), .busy(busy), .run(run), .err_ie(err_ie),
  .done_flag(done_flag), .err_flag(err_flag),
  .tail_idx(tail_idx), .head_idx(head_idx), .ring_last(ring_last)
);

// File: tb/tb_drd_ring_ctrl.sv
module tb_drd_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        xfer_valid, xfer_done;
  logic [7:0]  xfer_tgt, xfer_wlen, xfer_rlen, xfer_ctrl;
  logic [63:0] xfer_dptr;
  logic [7:0]  xfer_status, xfer_retry, xfer_rxcnt, xfer_txcnt;
  logic        irq;

  always #2 clk = ~clk;

  drd_ring_ctrl dut (.*);

  int n_checks = 0;
  int n_errors = 0;
  int eng_delay = 3;
  int eng_cnt = 0;
  logic [31:0] mem [0:255];
  logic [95:0] exp_q [$];

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SIZE = 5'h08,
                         A_BLO = 5'h10, A_BHI = 5'h14;
  localparam int BASE_W = 32'h40;

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wb_word(logic [7:0] tgt, logic [7:0] wl, logic [7:0] rl);
    return {wl, rl, 8'h02, (tgt[7:1] == 7'h7F) ? 8'h08 : 8'h01};
  endfunction

  // memory model: ack one cycle after request, alternating
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    end else mem_ack <= 1'b0;
  end

  // engine model
  always @(posedge clk) begin
    if (!rst_n) begin xfer_done <= 1'b0; eng_cnt <= 0; end
    else if (xfer_valid && !xfer_done) begin
      if (eng_cnt >= eng_delay) begin
        xfer_done   <= 1'b1;
        xfer_status <= (xfer_tgt[7:1] == 7'h7F) ? 8'h08 : 8'h01;
        xfer_retry  <= 8'h02;
        xfer_rxcnt  <= xfer_rlen;
        xfer_txcnt  <= xfer_wlen;
        eng_cnt     <= 0;
      end else eng_cnt <= eng_cnt + 1;
    end else xfer_done <= 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && xfer_valid && xfer_done) begin
      if (exp_q.size() == 0) check("R2 unexpected descriptor", {xfer_tgt, 88'h0}, 96'h0 - 1);
      else check("R2 descriptor fields", {xfer_tgt, xfer_wlen, xfer_rlen, xfer_ctrl, xfer_dptr},
                 exp_q.pop_front());
    end
    if (rst_n && mem_req) check("R11 base high half", 96'(mem_addr[63:32]), 96'h1);
  end

  task automatic reg_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_desc(int idx, logic [7:0] tgt, logic [7:0] wl, logic [7:0] rl,
                          logic [7:0] ct, logic [63:0] dp, bit push);
    mem[BASE_W + idx*4 + 0] = {ct, rl, wl, tgt};
    mem[BASE_W + idx*4 + 1] = 32'hDEADBEEF;
    mem[BASE_W + idx*4 + 2] = dp[31:0];
    mem[BASE_W + idx*4 + 3] = dp[63:32];
    if (push) exp_q.push_back({tgt, wl, rl, ct, dp});
  endtask

  task automatic chk_desc(string req, int idx, logic [7:0] tgt, logic [7:0] wl, logic [7:0] rl,
                          logic [7:0] ct, logic [63:0] dp, bit ran);
    check({req, " word0 kept"}, 96'(mem[BASE_W + idx*4]), 96'({ct, rl, wl, tgt}));
    check({req, " dptr kept"}, 96'({mem[BASE_W + idx*4 + 3], mem[BASE_W + idx*4 + 2]}), 96'(dp));
    check({req, " word1"}, 96'(mem[BASE_W + idx*4 + 1]),
          96'(ran ? wb_word(tgt, wl, rl) : 32'hDEADBEEF));
  endtask

  task automatic wait_idle(logic [7:0] tail);
    logic [31:0] d;
    do reg_read(A_STAT, d); while (d[0] || d[23:16] != tail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_read(A_CTRL, d); check("R1 ctrl", 96'(d), 96'h0);
    reg_read(A_STAT, d); check("R1 stat", 96'(d), 96'h0);
    reg_read(A_SIZE, d); check("R1 size", 96'(d), 96'h0);
    check("R1 outputs", 96'({irq, mem_req, xfer_valid}), 96'h0);

    // R11 setup
    reg_write(A_SIZE, 32'h3);
    reg_write(A_BLO, 32'h100);
    reg_write(A_BHI, 32'h1);
    reg_read(A_BHI, d); check("R11 base high", 96'(d), 96'h1);
    reg_read(A_SIZE, d); check("R11 size", 96'(d), 96'h3);

    // two descriptors, only the second asks for an interrupt
    eng_delay = 20;
    put_desc(0, 8'hA0, 8'h02, 8'h00, 8'h00, 64'h11223344_55667788, 1);
    put_desc(1, 8'hA3, 8'h5C, 8'h01, 8'h41, 64'h99AABBCC_DDEEFF00, 1);
    reg_write(A_CTRL, 32'h0002_0001);
    repeat (12) @(negedge clk);
    reg_read(A_STAT, d); check("R5 busy during transfer", 96'(d[0]), 96'h1);
    wait_idle(8'd2);
    chk_desc("R3 idx0", 0, 8'hA0, 8'h02, 8'h00, 8'h00, 64'h11223344_55667788, 1);
    chk_desc("R3 idx1", 1, 8'hA3, 8'h5C, 8'h01, 8'h41, 64'h99AABBCC_DDEEFF00, 1);
    reg_read(A_STAT, d); check("R7 done set, R5 tail", 96'(d), 96'h0002_0020);
    check("R9 irq high", 96'(irq), 96'h1);

    // R9 clear
    reg_write(A_STAT, 32'h20);
    reg_read(A_STAT, d); check("R9 done cleared", 96'(d[5:4]), 96'h0);
    check("R9 irq low", 96'(irq), 96'h0);

    // R4 wrap: 2,3,0
    eng_delay = 2;
    put_desc(2, 8'h20, 8'h03, 8'h02, 8'h00, 64'h1, 1);
    put_desc(3, 8'h22, 8'h04, 8'h00, 8'h00, 64'h2, 1);
    put_desc(0, 8'h24, 8'h05, 8'h01, 8'h00, 64'h3, 1);
    reg_write(A_CTRL, 32'h0001_0001);
    wait_idle(8'd1);
    chk_desc("R4 idx3", 3, 8'h22, 8'h04, 8'h00, 8'h00, 64'h2, 1);
    chk_desc("R4 idx0 after wrap", 0, 8'h24, 8'h05, 8'h01, 8'h00, 64'h3, 1);
    reg_read(A_STAT, d); check("R7 no done without bit6", 96'(d[5]), 96'h0);

    // R8 failure with enable off
    put_desc(1, 8'hFE, 8'h01, 8'h00, 8'h00, 64'h4, 1);
    reg_write(A_CTRL, 32'h0002_0001);
    wait_idle(8'd2);
    chk_desc("R3 failed idx1", 1, 8'hFE, 8'h01, 8'h00, 8'h00, 64'h4, 1);
    reg_read(A_STAT, d); check("R8 no err when disabled", 96'(d[4]), 96'h0);
    check("R9 irq idle", 96'(irq), 96'h0);

    // R10 stop on error with enable on
    put_desc(2, 8'hFF, 8'h06, 8'h00, 8'h80, 64'h5, 1);
    put_desc(3, 8'h30, 8'h07, 8'h00, 8'h00, 64'h6, 0);
    reg_write(A_CTRL, 32'h0000_0011);
    wait_idle(8'd3);
    repeat (10) @(negedge clk);
    reg_read(A_STAT, d); check("R8 err set, R10 tail held", 96'(d), 96'h0003_0010);
    reg_read(A_CTRL, d); check("R10 run cleared", 96'(d), 96'h0000_0010);
    chk_desc("R10 idx3 untouched", 3, 8'h30, 8'h07, 8'h00, 8'h00, 64'h6, 0);
    check("R9 irq on err", 96'(irq), 96'h1);
    reg_write(A_STAT, 32'h10);
    reg_read(A_STAT, d); check("R9 err cleared", 96'(d[4]), 96'h0);

    // R6 stop mid-descriptor: 3,0,1 pending
    eng_delay = 40;
    put_desc(3, 8'h32, 8'h08, 8'h03, 8'h40, 64'h7, 1);
    put_desc(0, 8'h34, 8'h09, 8'h00, 8'h00, 64'h8, 0);
    reg_write(A_CTRL, 32'h0002_0001);
    repeat (20) @(negedge clk);
    reg_write(A_CTRL, 32'h0002_0000);
    reg_read(A_STAT, d); check("R6 busy until finish", 96'(d[0]), 96'h1);
    wait_idle(8'd0);
    repeat (20) @(negedge clk);
    reg_read(A_STAT, d); check("R6 stopped after one, R7 done", 96'(d), 96'h0000_0020);
    chk_desc("R6 idx3 finished", 3, 8'h32, 8'h08, 8'h03, 8'h40, 64'h7, 1);
    chk_desc("R6 idx0 not started", 0, 8'h34, 8'h09, 8'h00, 8'h00, 64'h8, 0);
    check("R2 scoreboard drained", 96'(exp_q.size()), 96'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule